// File: doc/BRIEF.md
# VVI Demand Pacing Controller

This block decides, cycle by cycle, whether a single heart chamber needs a stimulus. It watches a sense line that marks detected intrinsic beats and a timebase tick from a prescaler. It drives two single-cycle event outputs. `beat_o` reports an intrinsic beat that was accepted. `pace_o` commands the lead driver to deliver a pace. If no accepted beat or pace occurs within the lower-rate interval, the block paces. After every beat or pace, a refractory window blanks any further sense until a shorter interval has elapsed.

Two retriggerable interval timers measure these windows in ticks: the lower-rate timer (`LRI_TICKS`) and the refractory timer (`REF_TICKS`). Both timers restart only on an accepted beat or on a pace. If neither happens, each timer fires again every period, so a silent heart is paced at the lower rate. A two-state machine holds the refractory flag:

- `ST_REFRACT`: the flag is set. This is the state after reset.
- `ST_ALERT`: the flag is clear.

The machine names five transitions:

| Transition | Cause | Effect |
|---|---|---|
| `TR_ACCEPT` | A sense arrives in `ST_ALERT`. | Issues a beat and moves to `ST_REFRACT`. |
| `TR_BLANK` | A sense arrives in `ST_REFRACT`. | No effect at all. |
| `TR_PACE` | The lower-rate timer expires and no sense is accepted in that cycle. | Issues a pace and moves to, or stays in, `ST_REFRACT`. |
| `TR_REF_END` | The refractory timer expires in `ST_REFRACT`. | Moves to `ST_ALERT` and issues nothing. |
| `TR_IDLE` | None of the above. | Nothing changes. |

The raw sense line is synchronised and edge-detected inside the block.

Top module: `vvi_pacer`

## Requirements
- R1: After reset, `beat_o` and `pace_o` are 0, the flag is set (`ST_REFRACT`) and both timers start from zero. A sense before the first refractory expiry produces no output, and the first pace follows `LRI_TICKS` ticks after reset.
- R2: When no sense is accepted, `pace_o` pulses on the `LRI_TICKS`-th tick after the last accepted beat, pace or reset, and it keeps pulsing every `LRI_TICKS` ticks.
- R3: On the `REF_TICKS`-th tick after the last beat, pace or reset, the flag clears (`ST_ALERT`) and neither output pulses.
- R4: A sense that arrives while the flag is set produces no output and restarts neither timer. This includes a sense in the cycle in which the refractory timer expires.
- R5: A sense that arrives while the flag is clear pulses `beat_o`, sets the flag and restarts both timers.
- R6: A pace sets the flag and restarts both timers.
- R7: Each rising edge of `sense_i` yields at most one internal sense event, however long the level is held.
- R8: If an accepted sense and a lower-rate expiry fall in the same cycle, only `beat_o` pulses. `beat_o` and `pace_o` are never high together.
- R9: Each output pulse lasts exactly one clock cycle and is registered one clock after the deciding event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Timebase tick, one cycle wide |
| sense_i | input | 1 | Raw sense level, asynchronous |
| beat_o | output | 1 | Accepted intrinsic beat, one-cycle pulse |
| pace_o | output | 1 | Pace command, one-cycle pulse |

## Verification
The embedded properties check several rules on every cycle:

- blanking in the refractory state (R4);
- the flag release on refractory expiry (R3);
- the priority of an accepted sense over a simultaneous pace (R8);
- exclusion of the two outputs;
- pulse width;
- timer bounds and timer restarts;
- that a sense edge makes a single internal event (R7).

Interval lengths are only visible over whole scenarios. These cover paces at every lower-rate interval, a sense rhythm that suppresses pacing, an ignored early sense that leaves the pace schedule intact, and a later accepted sense that shifts it. The bench also sweeps the sense arrival across the lower-rate expiry, which shows that exactly one event results whatever the alignment.

// File: rtl/vvi_pkg.sv
package vvi_pkg;

    // Refractory flag as a state: set = ST_REFRACT, clear = ST_ALERT
    typedef enum logic [0:0] {
        ST_REFRACT = 1'b0,
        ST_ALERT   = 1'b1
    } pace_state_t;

    // Transition taken in the current cycle
    typedef enum logic [2:0] {
        TR_IDLE    = 3'd0,
        TR_ACCEPT  = 3'd1,
        TR_BLANK   = 3'd2,
        TR_PACE    = 3'd3,
        TR_REF_END = 3'd4
    } pace_trans_t;

    // Timer slots in the timer array
    localparam int unsigned TMR_COUNT = 2;
    localparam int unsigned TMR_LRI   = 0;
    localparam int unsigned TMR_REF   = 1;

endpackage

// File: rtl/vvi_sense_sync.sv
module vvi_sense_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sense_i,
    output logic sense_evt_o
);

    localparam int unsigned CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN_W-2:0], sense_i};
        end
    end

    // Rising edge of the synchronised level
    assign sense_evt_o = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

    AST_SENSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sense_evt_o |=> !sense_evt_o); // R7

endmodule

// File: rtl/vvi_interval_timer.sv
module vvi_interval_timer #(
    parameter int unsigned PERIOD = 10
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic restart_i,
    output logic expire_o
);

    localparam int unsigned CNT_W = $clog2(PERIOD + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             at_last;

    assign at_last  = (cnt_q == LAST);
    assign expire_o = tick_i && at_last;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (restart_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            if (at_last) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q < CNT_W'(PERIOD)); // R2

    AST_RESTART_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |=> (cnt_q == '0)); // R6

    AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !restart_i) |=> $stable(cnt_q)); // R4

endmodule

// File: rtl/vvi_pacer.sv
module vvi_pacer
    import vvi_pkg::*;
#(
    parameter int unsigned LRI_TICKS   = 100,
    parameter int unsigned REF_TICKS   = 30,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic sense_i,
    output logic beat_o,
    output logic pace_o
);

    logic                 sense_evt;
    logic [TMR_COUNT-1:0] tmr_exp;
    logic                 lri_exp;
    logic                 ref_exp;
    logic                 restart;

    pace_state_t state_q, state_d;
    pace_trans_t trans;

    vvi_sense_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sense_i    (sense_i),
        .sense_evt_o(sense_evt)
    );

    for (genvar g = 0; g < TMR_COUNT; g++) begin : g_tmr
        localparam int unsigned PER = (g == TMR_LRI) ? LRI_TICKS : REF_TICKS;
        vvi_interval_timer #(
            .PERIOD(PER)
        ) u_tmr (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .tick_i   (tick_i),
            .restart_i(restart),
            .expire_o (tmr_exp[g])
        );
    end

    assign lri_exp = tmr_exp[TMR_LRI];
    assign ref_exp = tmr_exp[TMR_REF];

    // Transition selection: accepted sense beats a pace, a pace beats refractory end
    always_comb begin
        trans = TR_IDLE;
        unique case (state_q)
            ST_ALERT: begin
                if (sense_evt) begin
                    trans = TR_ACCEPT;
                end else if (lri_exp) begin
                    trans = TR_PACE;
                end
            end
            ST_REFRACT: begin
                if (lri_exp) begin
                    trans = TR_PACE;
                end else if (ref_exp) begin
                    trans = TR_REF_END;
                end else if (sense_evt) begin
                    trans = TR_BLANK;
                end
            end
            default: trans = TR_IDLE;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (trans)
            TR_ACCEPT:  state_d = ST_REFRACT;
            TR_PACE:    state_d = ST_REFRACT;
            TR_REF_END: state_d = ST_ALERT;
            TR_BLANK:   state_d = state_q;
            default:    state_d = state_q;
        endcase
    end

    assign restart = (trans == TR_ACCEPT) || (trans == TR_PACE);

    // State register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_REFRACT;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            beat_o <= 1'b0;
            pace_o <= 1'b0;
        end else begin
            beat_o <= (trans == TR_ACCEPT);
            pace_o <= (trans == TR_PACE);
        end
    end

    AST_NO_DUAL_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(beat_o && pace_o)); // R8

    AST_SENSE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_ALERT && sense_evt && lri_exp) |=> (beat_o && !pace_o)); // R8

    AST_BEAT_ENTERS_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        beat_o |-> (state_q == ST_REFRACT)); // R5

    AST_PACE_ENTERS_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pace_o |-> (state_q == ST_REFRACT)); // R6

    AST_BLANKED_SENSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_REFRACT && sense_evt) |=> !beat_o); // R4

    AST_REF_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_REFRACT && ref_exp && !lri_exp) |=>
            (state_q == ST_ALERT && !beat_o && !pace_o)); // R3

    AST_BEAT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        beat_o |=> !beat_o); // R9

    AST_PACE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pace_o |=> !pace_o); // R9

endmodule

// File: tb/vvi_pacer_tb_top.sv
`timescale 1ns/1ps
module vvi_pacer_tb_top;

    localparam int LRI      = 10;
    localparam int REFR     = 3;
    localparam int END_TICK = 32;
    localparam int NROWS    = 7;

    // Event kinds recorded by the monitor: 1 = beat, 2 = pace
    typedef struct packed {
        int s0; int s1; int s2; int hold;
        int k0; int t0; int k1; int t1; int k2; int t2;
    } row_t;

    localparam row_t ROWS [NROWS] = '{
        '{0,  0,  0,  3, 2, 10, 2, 20, 2, 30},  // silent heart
        '{9,  18, 27, 3, 1, 9,  1, 18, 1, 27},  // rhythm faster than lower rate
        '{12, 0,  0,  3, 2, 10, 2, 20, 2, 30},  // sense inside refractory after pace
        '{12, 14, 0,  3, 2, 10, 1, 14, 2, 24},  // ignored then accepted sense
        '{3,  0,  0,  3, 1, 3,  2, 13, 2, 23},  // sense right after first refractory end
        '{2,  0,  0,  3, 2, 10, 2, 20, 2, 30},  // sense before first refractory end
        '{5,  0,  0,  40, 1, 5, 2, 15, 2, 25}   // long sense level
    };

    function automatic string row_req(input int i);
        case (i)
            0: return "R2 R6";
            1: return "R5";
            2: return "R4 R6";
            3: return "R4 R5";
            4: return "R3 R5";
            5: return "R1 R4";
            default: return "R7";
        endcase
    endfunction

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic sense = 1'b0;
    logic beat, pace;
    logic [2:0] div = 3'd0;
    int tick_n = 0;

    int n_checks = 0;
    int n_fail = 0;
    int ev_kind [8];
    int ev_tick [8];
    int ev_cnt = 0;
    logic clr = 1'b1;
    logic pb = 1'b0;
    logic pp = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) begin
            div <= 3'd0;
            tick <= 1'b0;
            tick_n <= 0;
        end else begin
            div <= div + 3'd1;
            tick <= (div == 3'd7);
            if (div == 3'd7) tick_n <= tick_n + 1;
        end
    end

    vvi_pacer #(
        .LRI_TICKS(LRI),
        .REF_TICKS(REFR),
        .SYNC_STAGES(2)
    ) dut_i (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .tick_i (tick),
        .sense_i(sense),
        .beat_o (beat),
        .pace_o (pace)
    );

    // Event monitor with pulse-width and exclusion checks
    always @(negedge clk) begin
        if (clr) begin
            ev_cnt = 0;
            pb = 1'b0;
            pp = 1'b0;
        end else begin
            if (beat && pace) begin
                n_checks++;
                n_fail++;
                $display("FAIL R8 both outputs high at tick %0d: actual 1 expected 0", tick_n);
            end
            if (beat) begin
                if (ev_cnt < 8) begin ev_kind[ev_cnt] = 1; ev_tick[ev_cnt] = tick_n; end
                ev_cnt++;
            end
            if (pace) begin
                if (ev_cnt < 8) begin ev_kind[ev_cnt] = 2; ev_tick[ev_cnt] = tick_n; end
                ev_cnt++;
            end
            if (pb) begin
                n_checks++;
                if (beat) begin
                    n_fail++;
                    $display("FAIL R9 beat pulse width: actual >1 expected 1 cycle");
                end
            end
            if (pp) begin
                n_checks++;
                if (pace) begin
                    n_fail++;
                    $display("FAIL R9 pace pulse width: actual >1 expected 1 cycle");
                end
            end
            pb = beat;
            pp = pace;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        clr = 1'b1;
        rst_n = 1'b0;
        sense = 1'b0;
        repeat (4) @(negedge clk);
        check(!beat && !pace, "R1", "outputs in reset", int'({beat, pace}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic wait_tick(input int t);
        do @(negedge clk); while (!(tick && tick_n == t));
    endtask

    task automatic pulse_sense(input int hold);
        sense = 1'b1;
        repeat (hold) @(negedge clk);
        sense = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        // Table-driven scenarios
        for (int i = 0; i < NROWS; i++) begin
            int ek [3];
            int et [3];
            ek = '{ROWS[i].k0, ROWS[i].k1, ROWS[i].k2};
            et = '{ROWS[i].t0, ROWS[i].t1, ROWS[i].t2};
            do_reset();
            if (ROWS[i].s0 > 0) begin wait_tick(ROWS[i].s0); pulse_sense(ROWS[i].hold); end
            if (ROWS[i].s1 > 0) begin wait_tick(ROWS[i].s1); pulse_sense(ROWS[i].hold); end
            if (ROWS[i].s2 > 0) begin wait_tick(ROWS[i].s2); pulse_sense(ROWS[i].hold); end
            wait_tick(END_TICK);
            repeat (4) @(negedge clk);
            check(ev_cnt == 3, row_req(i), $sformatf("row %0d event count", i), ev_cnt, 3);
            for (int j = 0; j < 3; j++) begin
                int ak;
                int at;
                ak = (j < ev_cnt) ? ev_kind[j] : -1;
                at = (j < ev_cnt) ? ev_tick[j] : -1;
                check(ak == ek[j], row_req(i), $sformatf("row %0d event %0d kind", i, j), ak, ek[j]);
                check(at == et[j], row_req(i), $sformatf("row %0d event %0d tick", i, j), at, et[j]);
            end
        end

        // R8: sweep sense arrival across the lower-rate expiry at tick 10
        for (int k = 0; k < 16; k++) begin
            int at0;
            do_reset();
            wait_tick(9);
            repeat (k) @(negedge clk);
            pulse_sense(3);
            wait_tick(13);
            check(ev_cnt == 1, "R8", $sformatf("offset %0d event count", k), ev_cnt, 1);
            at0 = (ev_cnt > 0) ? ev_tick[0] : -1;
            check(at0 == 9 || at0 == 10, "R8", $sformatf("offset %0d event tick", k), at0, 10);
        end

        // R1: directed reset in the middle of operation restarts the schedule
        do_reset();
        wait_tick(7);
        do_reset();
        wait_tick(LRI);
        repeat (3) @(negedge clk);
        check(ev_cnt == 1 && ev_kind[0] == 2, "R1", "pace after mid-run reset", ev_cnt, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule